// File: doc/BRIEF.md
# Misalignment-Splitting Load/Store Unit

This unit sits between a processor core and a memory organised as 8-byte words. The core hands it one load or store at a time: 1, 2, 4 or 8 bytes at any byte address. The unit decides whether the access is aligned to its own size. It then either rejects the access or carries it out with one or two aligned word accesses on the memory port. On that port it places store bytes into their lanes under per-byte enables, and it gathers load bytes back out of the returned words.

Two configuration inputs set the behaviour. The first chooses how the bytes of a value map onto ascending addresses. The second chooses what happens to a misaligned request: it is either refused with a fault or serviced in hardware. The memory port has a request handshake and a completion strobe, and it carries one access at a time. Caches, address translation and pipelined requests play no part.

Top module: `lsu_split_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_valid` are 0.
- R2: `req_size` selects the access width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. An aligned load makes exactly one memory access, at the word address (low 3 bits zero). Byte lane j of `mem_rdata`/`mem_wdata` (bits 8j+7:8j) holds the byte at word address + j.
- R3: A request is misaligned when its address modulo its size is not zero. With `cfg_trap_misaligned` = 1, a misaligned request gets `rsp_valid` with `rsp_fault` = 1 and `rsp_rdata` = 0 on the cycle after acceptance. No memory access is made, so memory is left unchanged.
- R4: With trapping off, a misaligned access whose bytes all fall within one 8-byte word (offset + size ≤ 8) uses exactly one memory access and returns the correct value.
- R5: An access with offset + size > 8 makes two memory accesses. The first goes to the lower word and the second to the lower word + 8. The response is raised only after the second completion.
- R6: Store byte enables cover exactly the addressed bytes. For a split store, the first write enables the bytes from the offset up to the end of the word, and the second write enables the remaining low lanes. Bytes outside the access keep their values.
- R7: With `cfg_big_endian` = 0, the lowest-addressed byte is the least significant byte of the value. With 1, it is the most significant byte. This holds for loads and stores, split or not.
- R8: For 1- and 2-byte loads, `req_signed` = 1 sign-extends the value to 64 bits and 0 zero-extends it. 4- and 8-byte results never carry sign fill.
- R9: `mem_valid` stays high, with address, write flag, enables and data stable, until `mem_ready`. At most one memory access is outstanding at a time.
- R10: Aligned requests never fault, even with trapping on.
- R11: `req_ready` is high only while the unit is idle. `rsp_valid` is a single-cycle pulse, after which `req_ready` returns high. Stores return `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_big_endian | input | 1 | 1: lowest address is the most significant byte |
| cfg_trap_misaligned | input | 1 | 1: misaligned requests fault |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Unit can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access width code |
| req_signed | input | 1 | Sign-extend 1/2-byte loads |
| req_addr | input | AW | Byte address |
| req_wdata | input | 64 | Store value, right-justified |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Request refused as misaligned |
| rsp_rdata | output | 64 | Load value |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_write | output | 1 | Memory access is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_be | output | 8 | Per-lane byte enables |
| mem_wdata | output | 64 | Write word |
| mem_rvalid | input | 1 | Access completion, with read data |
| mem_rdata | input | 64 | Read word |

## Verification
A wrong phase or split decision shows up at the memory port within a handful of cycles. The symptoms are a missing or extra access, a second address other than the first plus 8, or enables that stray outside the addressed bytes. Lane steering or byte order errors corrupt neighbouring memory bytes or the loaded value at the very next response. The bench therefore checks access counts, logged addresses and enables, and every byte around each store. A lost completion or a premature response breaks the one-response-after-last-completion ordering on the same request.

// File: rtl/lsu_pkg.sv
// Shared types and helpers for the splitting load/store unit.
// Assumes values are at most 8 bytes wide.
package lsu_pkg;
    localparam int VAL_BYTES = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } lsu_state_e;

    // Number of bytes moved by a size code (0..3 -> 1,2,4,8).
    function automatic logic [3:0] size_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction
endpackage

// File: rtl/lsu_lane_mapper.sv
// Places a store value into a two-word byte window at the given offset.
// It produces the per-word enables and data, plus the split flag.
// Assumes WB >= VAL_BYTES and WB a power of two.
module lsu_lane_mapper
    import lsu_pkg::*;
#(
    parameter int WB = 8
) (
    input  logic [1:0]           size,
    input  logic [$clog2(WB)-1:0] offset,
    input  logic                 big_endian,
    input  logic [63:0]          wdata,
    output logic [WB-1:0]        be_lo,
    output logic [WB-1:0]        be_hi,
    output logic [8*WB-1:0]      wd_lo,
    output logic [8*WB-1:0]      wd_hi,
    output logic                 split
);
    localparam int OW   = $clog2(WB);
    localparam int WINB = 2 * WB;

    logic [3:0]          nb;
    logic [7:0]          vmask;
    logic [63:0]         stream;
    logic [WINB-1:0]     be_win;
    logic [8*WINB-1:0]   d_win;

    assign nb = size_bytes(size);

    // Reorder value bytes into ascending-address order and mark the used bytes.
    always_comb begin
        stream = '0;
        vmask  = '0;
        for (int i = 0; i < VAL_BYTES; i++) begin
            if (i < int'(nb)) begin
                vmask[i] = 1'b1;
                if (big_endian)
                    stream[8*i +: 8] = wdata[8*(int'(nb) - 1 - i) +: 8];
                else
                    stream[8*i +: 8] = wdata[8*i +: 8];
            end
        end
    end

    // Shift the byte stream and its mask up to the access offset.
    always_comb begin
        be_win = {{(WINB-8){1'b0}}, vmask} << offset;
        d_win  = {{(8*WINB-64){1'b0}}, stream} << {offset, 3'b000};
    end

    assign be_lo = be_win[WB-1:0];
    assign be_hi = be_win[WINB-1:WB];
    assign wd_lo = d_win[8*WB-1:0];
    assign wd_hi = d_win[8*WINB-1:8*WB];
    assign split = ({1'b0, offset} + (OW+1)'(nb)) > (OW+1)'(WB);
endmodule

// File: rtl/lsu_load_merge.sv
// Extracts a load value from two captured words at a byte offset.
// It applies the byte order and the sign or zero extension.
// Assumes word_hi is only meaningful when the access crossed a word boundary.
module lsu_load_merge
    import lsu_pkg::*;
#(
    parameter int WB = 8
) (
    input  logic [8*WB-1:0]       word_lo,
    input  logic [8*WB-1:0]       word_hi,
    input  logic [$clog2(WB)-1:0] offset,
    input  logic [1:0]            size,
    input  logic                  big_endian,
    input  logic                  sign_ext,
    output logic [63:0]           value
);
    localparam int WINB = 2 * WB;

    logic [8*WINB-1:0] win;
    logic [3:0]        nb;

    assign nb  = size_bytes(size);
    assign win = {word_hi, word_lo} >> {offset, 3'b000};

    // Gather the bytes in value order, then fill the upper bits.
    always_comb begin
        value = '0;
        for (int i = 0; i < VAL_BYTES; i++) begin
            if (i < int'(nb)) begin
                if (big_endian)
                    value[8*i +: 8] = win[8*(int'(nb) - 1 - i) +: 8];
                else
                    value[8*i +: 8] = win[8*i +: 8];
            end
        end
        if (sign_ext && nb <= 4'd2) begin
            for (int k = 8; k < 64; k++) begin
                if (k >= 8*int'(nb))
                    value[k] = value[8*int'(nb) - 1];
            end
        end
    end
endmodule

// File: rtl/lsu_split_unit.sv
// Load/store unit for byte-addressed accesses of 1..8 bytes over a word memory.
// Misaligned requests are either faulted or split into two aligned accesses.
// Assumes the memory returns exactly one mem_rvalid for each accepted access.
module lsu_split_unit
    import lsu_pkg::*;
#(
    parameter int AW = 32,
    parameter int WB = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_big_endian,
    input  logic            cfg_trap_misaligned,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic [1:0]      req_size,
    input  logic            req_signed,
    input  logic [AW-1:0]   req_addr,
    input  logic [63:0]     req_wdata,
    output logic            rsp_valid,
    output logic            rsp_fault,
    output logic [63:0]     rsp_rdata,
    output logic            mem_valid,
    input  logic            mem_ready,
    output logic            mem_write,
    output logic [AW-1:0]   mem_addr,
    output logic [WB-1:0]   mem_be,
    output logic [8*WB-1:0] mem_wdata,
    input  logic            mem_rvalid,
    input  logic [8*WB-1:0] mem_rdata
);
    localparam int OW = $clog2(WB);

    lsu_state_e      state;
    logic            phase;
    logic            r_write, r_signed, r_big, r_fault;
    logic [1:0]      r_size;
    logic [AW-1:0]   r_addr;
    logic [63:0]     r_wdata;
    logic [8*WB-1:0] word_lo, word_hi;

    logic            misaligned;
    logic [WB-1:0]   be_lo, be_hi;
    logic [8*WB-1:0] wd_lo, wd_hi;
    logic            split;
    logic [63:0]     merged;
    logic [AW-1:0]   base_addr;

    assign misaligned = |(req_addr[2:0] & 3'((4'd1 << req_size) - 4'd1));
    assign base_addr  = {r_addr[AW-1:OW], {OW{1'b0}}};

    lsu_lane_mapper #(.WB(WB)) i_mapper (
        .size       (r_size),
        .offset     (r_addr[OW-1:0]),
        .big_endian (r_big),
        .wdata      (r_wdata),
        .be_lo      (be_lo),
        .be_hi      (be_hi),
        .wd_lo      (wd_lo),
        .wd_hi      (wd_hi),
        .split      (split)
    );

    lsu_load_merge #(.WB(WB)) i_merge (
        .word_lo    (word_lo),
        .word_hi    (word_hi),
        .offset     (r_addr[OW-1:0]),
        .size       (r_size),
        .big_endian (r_big),
        .sign_ext   (r_signed),
        .value      (merged)
    );

    // Sequence: accept, issue phase 0, optionally phase 1, then respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            phase    <= 1'b0;
            r_write  <= 1'b0;
            r_signed <= 1'b0;
            r_big    <= 1'b0;
            r_fault  <= 1'b0;
            r_size   <= 2'd0;
            r_addr   <= '0;
            r_wdata  <= '0;
            word_lo  <= '0;
            word_hi  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        r_write  <= req_write;
                        r_signed <= req_signed;
                        r_big    <= cfg_big_endian;
                        r_size   <= req_size;
                        r_addr   <= req_addr;
                        r_wdata  <= req_wdata;
                        word_lo  <= '0;
                        word_hi  <= '0;
                        phase    <= 1'b0;
                        if (misaligned && cfg_trap_misaligned) begin
                            r_fault <= 1'b1;
                            state   <= ST_RESP;
                        end else begin
                            r_fault <= 1'b0;
                            state   <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (mem_ready) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        if (phase) word_hi <= mem_rdata;
                        else       word_lo <= mem_rdata;
                        if (!phase && split) begin
                            phase <= 1'b1;
                            state <= ST_ISSUE;
                        end else begin
                            state <= ST_RESP;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory port driven from the current phase.
    always_comb begin
        mem_valid = (state == ST_ISSUE);
        mem_write = r_write;
        mem_addr  = phase ? base_addr + AW'(WB) : base_addr;
        mem_be    = phase ? be_hi : be_lo;
        mem_wdata = phase ? wd_hi : wd_lo;
    end

    // Core-side handshake and response.
    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_RESP);
        rsp_fault = rsp_valid && r_fault;
        rsp_rdata = (rsp_valid && !r_fault && !r_write) ? merged : '0;
    end
endmodule

// File: rtl/lsu_split_checker.sv
// Protocol and ordering properties for lsu_split_unit, attached by bind.
// Assumes synchronous active-low reset.
module lsu_split_checker #(
    parameter int AW = 32,
    parameter int WB = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_trap_misaligned,
    input logic          req_valid,
    input logic          req_ready,
    input logic [1:0]    req_size,
    input logic [AW-1:0] req_addr,
    input logic          rsp_valid,
    input logic          rsp_fault,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic          mem_write,
    input logic [AW-1:0] mem_addr,
    input logic [WB-1:0] mem_be,
    input logic          mem_rvalid
);
    localparam int OW = $clog2(WB);

    logic chk_misal;
    logic outstanding;

    assign chk_misal = (req_size == 2'd1 && req_addr[0]) ||
                       (req_size == 2'd2 && req_addr[1:0] != 2'd0) ||
                       (req_size == 2'd3 && req_addr[2:0] != 3'd0);

    // Track whether a memory access is awaiting completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                      outstanding <= 1'b0;
        else if (mem_valid && mem_ready) outstanding <= 1'b1;
        else if (mem_rvalid)             outstanding <= 1'b0;
    end

    assert_trap_no_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && cfg_trap_misaligned && chk_misal
        |=> rsp_valid && rsp_fault && !mem_valid);

    assert_aligned_proceeds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !chk_misal |=> mem_valid && !rsp_valid);

    assert_hold_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
        $stable(mem_be) && $stable(mem_write));

    assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !outstanding);

    assert_completion_expected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> outstanding);

    assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_addr[OW-1:0] == '0 && mem_be != '0);

    assert_resp_after_completion_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> $past(mem_rvalid));

    assert_resp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready ##1 (!rsp_valid && req_ready));
endmodule

bind lsu_split_unit lsu_split_checker #(.AW(AW), .WB(WB)) i_lsu_checker (
    .clk                 (clk),
    .rst_n               (rst_n),
    .cfg_trap_misaligned (cfg_trap_misaligned),
    .req_valid           (req_valid),
    .req_ready           (req_ready),
    .req_size            (req_size),
    .req_addr            (req_addr),
    .rsp_valid           (rsp_valid),
    .rsp_fault           (rsp_fault),
    .mem_valid           (mem_valid),
    .mem_ready           (mem_ready),
    .mem_write           (mem_write),
    .mem_addr            (mem_addr),
    .mem_be              (mem_be),
    .mem_rvalid          (mem_rvalid)
);

// File: tb/test_lsu_split_unit.sv
`timescale 1ns/1ps
module test_lsu_split_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_big_endian = 1'b0;
    logic        cfg_trap_misaligned = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_signed = 1'b0;
    logic [31:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, rsp_fault;
    logic [63:0] rsp_rdata;
    logic        mem_valid, mem_ready, mem_write;
    logic [31:0] mem_addr;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int stall_cfg = 0;
    int wait_cnt = 0;
    int acc_cnt = 0;
    int valid_cycles = 0;
    logic [7:0]  mem_b [0:63];
    logic [31:0] log_addr [0:255];
    logic [7:0]  log_be [0:255];

    always #2.5 clk = ~clk;

    lsu_split_unit i_lsu_split_unit (
        .clk(clk), .rst_n(rst_n),
        .cfg_big_endian(cfg_big_endian), .cfg_trap_misaligned(cfg_trap_misaligned),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_rdata(rsp_rdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    assign mem_ready = (wait_cnt == 0);

    // Memory model: 64 bytes, optional stall, completion one cycle after accept.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem_b[i] <= 8'(8'h10 + i);
            mem_rvalid <= 1'b0;
            wait_cnt <= 0;
            acc_cnt <= 0;
            valid_cycles <= 0;
        end else begin
            mem_rvalid <= 1'b0;
            if (mem_valid) valid_cycles <= valid_cycles + 1;
            if (mem_valid && mem_ready) begin
                log_addr[acc_cnt[7:0]] <= mem_addr;
                log_be[acc_cnt[7:0]] <= mem_be;
                acc_cnt <= acc_cnt + 1;
                for (int j = 0; j < 8; j++) begin
                    mem_rdata[8*j +: 8] <= mem_b[int'(mem_addr[5:0]) + j];
                    if (mem_write && mem_be[j])
                        mem_b[int'(mem_addr[5:0]) + j] <= mem_wdata[8*j +: 8];
                end
                mem_rvalid <= 1'b1;
                wait_cnt <= stall_cfg;
            end else if (mem_valid && wait_cnt != 0) begin
                wait_cnt <= wait_cnt - 1;
            end else if (!mem_valid) begin
                wait_cnt <= stall_cfg;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected load value computed from the memory bytes and the requirements.
    function automatic logic [63:0] model_load(input int a, input logic [1:0] sz,
                                               input logic sg, input logic be);
        int n = 1 << sz;
        logic [63:0] v = '0;
        for (int i = 0; i < 8; i++) begin
            if (i < n) begin
                if (be) v[8*(n-1-i) +: 8] = mem_b[(a + i) & 63];
                else    v[8*i +: 8] = mem_b[(a + i) & 63];
            end
        end
        if (sg && n <= 2 && v[8*n-1])
            for (int k = 0; k < 64; k++) if (k >= 8*n) v[k] = 1'b1;
        return v;
    endfunction

    // Issue one request and wait for its response; lat counts negedges after acceptance.
    task automatic run_req(input logic wr, input logic [1:0] sz, input logic sg,
                           input int a, input logic [63:0] wd,
                           output logic flt, output logic [63:0] rd, output int lat);
        @(negedge clk);
        chk("R11 ready while idle", {63'd0, req_ready}, 64'd1);
        req_write = wr; req_size = sz; req_signed = sg;
        req_addr = 32'(a); req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        flt = rsp_fault;
        rd = rsp_rdata;
        if (lat >= 200) chk("response timeout", 64'd0, 64'd1);
    endtask

    task automatic t_reset;
        chk("R1 req_ready", {63'd0, req_ready}, 64'd1);
        chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        chk("R1 mem_valid", {63'd0, mem_valid}, 64'd0);
    endtask

    task automatic t_aligned_le;
        logic f; logic [63:0] d; int l; int c0;
        cfg_big_endian = 1'b0; cfg_trap_misaligned = 1'b0;
        for (int s = 0; s < 4; s++) begin
            c0 = acc_cnt;
            run_req(1'b0, 2'(s), 1'b0, 16, '0, f, d, l);
            chk("R2 aligned load value", d, model_load(16, 2'(s), 1'b0, 1'b0));
            chk("R2 one access", 64'(acc_cnt - c0), 64'd1);
            chk("R2 word address", 64'(log_addr[c0[7:0]]), 64'd16);
        end
    endtask

    task automatic t_trap;
        logic f; logic [63:0] d; int l; int c0; logic [7:0] keep;
        cfg_trap_misaligned = 1'b1;
        c0 = acc_cnt;
        run_req(1'b0, 2'd1, 1'b0, 1, '0, f, d, l);
        chk("R3 fault flag", {63'd0, f}, 64'd1);
        chk("R3 fault data zero", d, 64'd0);
        chk("R3 fault latency", 64'(l), 64'd1);
        chk("R3 no memory access", 64'(acc_cnt - c0), 64'd0);
        keep = mem_b[9];
        run_req(1'b1, 2'd2, 1'b0, 9, 64'hDEADBEEF, f, d, l);
        chk("R3 store fault", {63'd0, f}, 64'd1);
        chk("R3 memory unchanged", 64'(mem_b[9]), 64'(keep));
        run_req(1'b0, 2'd3, 1'b0, 8, '0, f, d, l);
        chk("R10 aligned no fault", {63'd0, f}, 64'd0);
        chk("R10 aligned value", d, model_load(8, 2'd3, 1'b0, 1'b0));
        cfg_trap_misaligned = 1'b0;
    endtask

    task automatic t_within_word;
        logic f; logic [63:0] d; int l; int c0;
        c0 = acc_cnt;
        run_req(1'b0, 2'd2, 1'b0, 2, '0, f, d, l);
        chk("R4 no fault", {63'd0, f}, 64'd0);
        chk("R4 single access", 64'(acc_cnt - c0), 64'd1);
        chk("R4 value", d, model_load(2, 2'd2, 1'b0, 1'b0));
    endtask

    task automatic t_split_load;
        logic f; logic [63:0] d; int l; int c0; int v0;
        stall_cfg = 3;
        @(negedge clk);
        @(negedge clk);
        c0 = acc_cnt; v0 = valid_cycles;
        run_req(1'b0, 2'd3, 1'b0, 5, '0, f, d, l);
        chk("R5 two accesses", 64'(acc_cnt - c0), 64'd2);
        chk("R5 first lower word", 64'(log_addr[c0[7:0]]), 64'd0);
        chk("R5 second upper word", 64'(log_addr[8'(c0 + 1)]), 64'd8);
        chk("R5 merged value", d, model_load(5, 2'd3, 1'b0, 1'b0));
        chk("R9 request held during stall", 64'(valid_cycles - v0), 64'd8);
        stall_cfg = 0;
        @(negedge clk);
    endtask

    task automatic t_split_store;
        logic f; logic [63:0] d; int l; int c0; logic [7:0] b5, b10;
        b5 = mem_b[5]; b10 = mem_b[10];
        c0 = acc_cnt;
        run_req(1'b1, 2'd2, 1'b0, 6, 64'hAABBCCDD, f, d, l);
        chk("R6 two writes", 64'(acc_cnt - c0), 64'd2);
        chk("R6 first enables", 64'(log_be[c0[7:0]]), 64'hC0);
        chk("R6 second enables", 64'(log_be[8'(c0 + 1)]), 64'h03);
        chk("R6 bytes placed", {32'd0, mem_b[9], mem_b[8], mem_b[7], mem_b[6]}, 64'hAABBCCDD);
        chk("R6 neighbour below", 64'(mem_b[5]), 64'(b5));
        chk("R6 neighbour above", 64'(mem_b[10]), 64'(b10));
        chk("R11 store rdata zero", d, 64'd0);
        c0 = acc_cnt;
        run_req(1'b1, 2'd0, 1'b0, 12, 64'h77, f, d, l);
        chk("R6 byte store enable", 64'(log_be[c0[7:0]]), 64'h10);
        chk("R6 byte store value", 64'(mem_b[12]), 64'h77);
    endtask

    task automatic t_endian;
        logic f; logic [63:0] d; int l;
        cfg_big_endian = 1'b1;
        run_req(1'b0, 2'd2, 1'b0, 8, '0, f, d, l);
        chk("R7 big-endian load", d, model_load(8, 2'd2, 1'b0, 1'b1));
        chk("R7 big-endian msb is low addr", {56'd0, d[31:24]}, 64'(mem_b[8]));
        run_req(1'b1, 2'd1, 1'b0, 20, 64'h0203, f, d, l);
        chk("R7 big-endian store order", {48'd0, mem_b[20], mem_b[21]}, 64'h0203);
        run_req(1'b1, 2'd3, 1'b0, 35, 64'h0102030405060708, f, d, l);
        chk("R7 big-endian split store first", 64'(mem_b[35]), 64'h01);
        chk("R7 big-endian split store last", 64'(mem_b[42]), 64'h08);
        run_req(1'b0, 2'd3, 1'b0, 35, '0, f, d, l);
        chk("R7 big-endian split round trip", d, 64'h0102030405060708);
        cfg_big_endian = 1'b0;
        run_req(1'b1, 2'd2, 1'b0, 24, 64'd515, f, d, l);
        chk("R7 little-endian store bytes",
            {32'd0, mem_b[24], mem_b[25], mem_b[26], mem_b[27]}, 64'h03020000);
        run_req(1'b0, 2'd2, 1'b0, 24, '0, f, d, l);
        chk("R7 little-endian 515", d, 64'd515);
    endtask

    task automatic t_sign;
        logic f; logic [63:0] d; int l;
        run_req(1'b1, 2'd0, 1'b0, 30, 64'hF0, f, d, l);
        run_req(1'b0, 2'd0, 1'b1, 30, '0, f, d, l);
        chk("R8 signed byte", d, 64'hFFFF_FFFF_FFFF_FFF0);
        run_req(1'b0, 2'd0, 1'b0, 30, '0, f, d, l);
        chk("R8 unsigned byte", d, 64'h0000_0000_0000_00F0);
        run_req(1'b1, 2'd1, 1'b0, 32, 64'h8001, f, d, l);
        run_req(1'b0, 2'd1, 1'b1, 32, '0, f, d, l);
        chk("R8 signed half", d, 64'hFFFF_FFFF_FFFF_8001);
        run_req(1'b1, 2'd2, 1'b0, 44, 64'h8000_0001, f, d, l);
        run_req(1'b0, 2'd2, 1'b1, 44, '0, f, d, l);
        chk("R8 long not sign filled", d, 64'h0000_0000_8000_0001);
        run_req(1'b0, 2'd1, 1'b1, 31, '0, f, d, l);
        chk("R8 signed misaligned half", d, model_load(31, 2'd1, 1'b1, 1'b0));
    endtask

    task automatic t_pulse;
        logic f; logic [63:0] d; int l;
        run_req(1'b0, 2'd0, 1'b0, 3, '0, f, d, l);
        chk("R11 not ready during response", {63'd0, req_ready}, 64'd0);
        @(negedge clk);
        chk("R11 response one cycle", {63'd0, rsp_valid}, 64'd0);
        chk("R11 ready after response", {63'd0, req_ready}, 64'd1);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_aligned_le();
        t_trap();
        t_within_word();
        t_split_load();
        t_split_store();
        t_endian();
        t_sign();
        t_pulse();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule